// File: doc/BRIEF.md
# Synchronous Burst Cache SRAM

This block is a single-port synchronous word memory meant to sit next to a processor as a cache store. Data is 32 bits wide, split into four 8-bit lanes, and the word address is 17 bits. The depth actually built is a parameter (`MEM_AW` address bits), so simulation can use a small array. An access starts when either of two active-low address strobes is sampled low while the part is selected: one strobe comes from the processor and the other from a cache controller. The start address is registered and a two-bit counter then walks the two low address bits on each advance request. The walk follows one of two orders, picked by `mode`: a wrapping increment or an XOR with the beat count.

Reads are flow-through. The word at the registered address appears on `dq_out` in the same cycle that the address was registered, with no extra output register. Writes take effect at the clock edge. A global write enable writes all lanes, or a byte-write enable together with per-lane selects writes only some lanes. The bus is modelled as `dq_out` plus a drive flag `dq_oe`. The flag stands for the three-state enable and is gated at once by `oe_n`. A sleep input freezes the block.

Top module: `burst_cache_sram`

## Requirements
- R1: After reset no burst is active, `dq_oe` is 0 and `dq_out` is 0.
- R2: A strobe is accepted only if `ce1_n`=0, `ce2`=1 and `ce3_n`=0 at the edge. A strobe seen while any enable is inactive ends the burst: nothing is written and the bus stays undriven until a new accepted strobe.
- R3: Either strobe (`adsp_n` or `adsc_n` low) loads `addr` and clears the beat counter. When both are low, `adsp_n` decides the cycle type.
- R4: With `mode`=0 the low two address bits on beat n are (start + n) mod 4. Bits 16..2 stay fixed, and a fifth beat returns to the start word.
- R5: With `mode`=1 the low two address bits on beat n are start XOR n. Bits 16..2 stay fixed.
- R6: The counter moves only at an edge with `adv_n`=0 and no strobe low. Otherwise the burst address is held.
- R7: Read data for the address registered at an edge is on `dq_out` after that same edge.
- R8: `gw_n`=0 writes all four lanes, whatever the values of `bwe_n` and `bw_n`.
- R9: With `gw_n`=1 and `bwe_n`=0, lane i (bits 8i+7..8i) is written only if `bw_n[i]`=0.
- R10: An accepted `adsp_n` strobe is always a read. The write enables are ignored and the memory word is unchanged.
- R11: `dq_oe`=1 only when all of these hold: `oe_n`=0, a burst is active, the last edge did no write, and `zz`=0. `oe_n` acts without a clock edge, and `dq_out` is 0 while undriven.
- R12: While `zz`=1, edges have no effect: nothing is written, the address and counter hold, no strobe is taken, and the bus is undriven.
- R13: Words whose address has bits at or above `MEM_AW` set are absent. Writes to them are dropped and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of control state |
| addr | input | 17 | Word address, taken by a strobe |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance request, active low |
| gw_n | input | 1 | Global write (all lanes), active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write selects, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| zz | input | 1 | Sleep, active high |
| mode | input | 1 | Burst order: 0 wrap-increment, 1 XOR |
| dq_in | input | 32 | Write data |
| dq_out | output | 32 | Read data, 0 when not driven |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The address walk runs from every start offset under both values of `mode`. The memory is first filled with words that encode their own address, so every beat shows which word was fetched. This separates the two orders where they differ: offsets 1 and 3 diverge, while offsets 0 and 2 agree. One extra beat checks the wrap. The write paths use lane patterns that differ in alternate lanes, which separates a global write from a partial byte write and also catches a lane-index swap. Corner tests combine a write request with a processor strobe, with a deselected strobe, and with sleep. In each of these the write must be dropped, and a later read shows that the word is untouched.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  localparam int LANE_W = 8;

  typedef enum logic {
    ORD_WRAP = 1'b0,
    ORD_XOR  = 1'b1
  } burst_order_e;

  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input burst_order_e ord);
    return (ord == ORD_XOR) ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import sram_burst_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          load,
  input  logic          drop,
  input  logic          step,
  input  burst_order_e  order,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] nxt_addr,
  output logic          nxt_active,
  output logic [AW-1:0] cur_addr,
  output logic          cur_active
);
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    beat_q, beat_d;
  logic          act_q, act_d;

  always_comb begin
    base_d = base_q;
    beat_d = beat_q;
    act_d  = act_q;
    if (!hold) begin
      if (load) begin
        base_d = start_addr;
        beat_d = 2'd0;
        act_d  = 1'b1;
      end else if (drop) begin
        act_d = 1'b0;
      end else if (act_q && step) begin
        beat_d = beat_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= 2'd0;
      act_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      beat_q <= beat_d;
      act_q  <= act_d;
    end
  end

  assign cur_addr   = {base_q[AW-1:2], burst_low(base_q[1:0], beat_q, order)};
  assign nxt_addr   = {base_d[AW-1:2], burst_low(base_d[1:0], beat_d, order)};
  assign cur_active = act_q;
  assign nxt_active = act_d;
endmodule

// File: rtl/byte_lane_decode.sv
module byte_lane_decode #(
  parameter int LANES = 4
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic [LANES-1:0] lane_we,
  output logic             any_we
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = !gw_n || (!bwe_n && !bw_n[i]);
  end
  assign any_we = |lane_we;
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_burst_pkg::*;
#(
  parameter int AW     = 17,
  parameter int MEM_AW = 6,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << MEM_AW;

  logic w_in_range, r_in_range;
  assign w_in_range = (waddr >> MEM_AW) == '0;
  assign r_in_range = (raddr >> MEM_AW) == '0;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lanes[i] && w_in_range)
        mem[waddr[MEM_AW-1:0]] <= wdata[i*LANE_W +: LANE_W];
    end

    assign rdata[i*LANE_W +: LANE_W] =
      r_in_range ? mem[raddr[MEM_AW-1:0]] : '0;
  end
endmodule

// File: rtl/burst_cache_sram.sv
module burst_cache_sram
  import sram_burst_pkg::*;
#(
  parameter int AW     = 17,
  parameter int DW     = 32,
  parameter int MEM_AW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic                adsp_n,
  input  logic                adsc_n,
  input  logic                adv_n,
  input  logic                gw_n,
  input  logic                bwe_n,
  input  logic [DW/LANE_W-1:0] bw_n,
  input  logic                ce1_n,
  input  logic                ce2,
  input  logic                ce3_n,
  input  logic                oe_n,
  input  logic                zz,
  input  logic                mode,
  input  logic [DW-1:0]       dq_in,
  output logic [DW-1:0]       dq_out,
  output logic                dq_oe
);
  localparam int LANES = DW / LANE_W;

  logic             sel, strobe, rd_force;
  logic             load, drop, step;
  logic [AW-1:0]    nxt_addr, cur_addr;
  logic             nxt_active, cur_active;
  logic [LANES-1:0] lane_we, wr_lanes;
  logic             any_we, wr_now, wr_last_q;
  logic [DW-1:0]    rd_word;

  assign sel      = !ce1_n && ce2 && !ce3_n;
  assign strobe   = !adsp_n || !adsc_n;
  assign rd_force = !adsp_n && sel;
  assign load     = strobe && sel;
  assign drop     = strobe && !sel;
  assign step     = !adv_n && !strobe;

  burst_addr_gen #(.AW(AW)) addr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (zz),
    .load       (load),
    .drop       (drop),
    .step       (step),
    .order      (burst_order_e'(mode)),
    .start_addr (addr),
    .nxt_addr   (nxt_addr),
    .nxt_active (nxt_active),
    .cur_addr   (cur_addr),
    .cur_active (cur_active)
  );

  byte_lane_decode #(.LANES(LANES)) lane_i (
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bw_n    (bw_n),
    .lane_we (lane_we),
    .any_we  (any_we)
  );

  assign wr_now   = !zz && nxt_active && !rd_force && any_we;
  assign wr_lanes = wr_now ? lane_we : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   wr_last_q <= 1'b0;
    else if (!zz) wr_last_q <= wr_now;
  end

  sram_lane_array #(.AW(AW), .MEM_AW(MEM_AW), .LANES(LANES)) mem_i (
    .clk      (clk),
    .wr_lanes (wr_lanes),
    .waddr    (nxt_addr),
    .wdata    (dq_in),
    .raddr    (cur_addr),
    .rdata    (rd_word)
  );

  assign dq_oe  = !oe_n && cur_active && !wr_last_q && !zz;
  assign dq_out = dq_oe ? rd_word : '0;
endmodule

// File: rtl/sram_burst_chk.sv
module sram_burst_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          zz,
  input logic          oe_n,
  input logic          sel,
  input logic          strobe,
  input logic          adv_n,
  input logic          mode,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] cur_addr,
  input logic          cur_active,
  input logic          dq_oe
);
  // R11
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!oe_n && !zz && cur_active));

  // R12
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> ($stable(cur_addr) || !$stable(mode)));

  // R3
  strobe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && sel && strobe) |=> (cur_addr == $past(addr) && cur_active));

  // R6
  no_adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && !strobe && adv_n) |=> ($stable(cur_addr) || !$stable(mode)));

  // R4
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && !strobe && !adv_n && cur_active)
      |=> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

  // R2
  deselect_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && !sel && strobe) |=> !cur_active);
endmodule

bind burst_cache_sram sram_burst_chk #(.AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .zz         (zz),
  .oe_n       (oe_n),
  .sel        (sel),
  .strobe     (strobe),
  .adv_n      (adv_n),
  .mode       (mode),
  .addr       (addr),
  .cur_addr   (cur_addr),
  .cur_active (cur_active),
  .dq_oe      (dq_oe)
);

// File: tb/burst_cache_sram_tb_top.sv
module burst_cache_sram_tb_top;
  localparam int AW = 17;
  localparam int DW = 32;
  localparam int MEM_AW = 6;

  // {mode, start[1:0], beat0, beat1, beat2, beat3}
  localparam logic [10:0] WALK [8] = '{
    {1'b0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b0, 2'd1, 2'd1, 2'd2, 2'd3, 2'd0},
    {1'b0, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1},
    {1'b0, 2'd3, 2'd3, 2'd0, 2'd1, 2'd2},
    {1'b1, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b1, 2'd1, 2'd1, 2'd0, 2'd3, 2'd2},
    {1'b1, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1},
    {1'b1, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic          gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]    bw_n = 4'hF;
  logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic          oe_n = 1'b0, zz = 1'b0, mode = 1'b0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_cache_sram #(.AW(AW), .DW(DW), .MEM_AW(MEM_AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .ce1_n(ce1_n),
    .ce2(ce2), .ce3_n(ce3_n), .oe_n(oe_n), .zz(zz), .mode(mode),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [31:0] pat(input int w);
    return 32'hC0DE_0000 | 32'(w);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic idle();
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    oe_n = 1'b0; zz = 1'b0;
  endtask

  task automatic rd_start(input int w);
    idle();
    adsp_n = 1'b0; addr = AW'(w);
    tick();
    idle();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R1 oe", 32'(dq_oe), 32'd0);
    chk("R1 data", dq_out, 32'd0);
    rst_n = 1'b1;
    tick();
    chk("R1 after release", 32'(dq_oe), 32'd0);

    // fill words 0..15 with self-describing data
    for (int w = 0; w < 16; w++) begin
      idle();
      adsc_n = 1'b0; gw_n = 1'b0; addr = AW'(w); dq_in = pat(w);
      tick();
      if (w == 0) chk("R11 write cycle undriven", 32'(dq_oe), 32'd0);
    end
    idle();

    // table walk: both orders, all start offsets, plus wrap beat
    for (int i = 0; i < 8; i++) begin
      logic [10:0] e;
      int base;
      e = WALK[i];
      base = (i % 4) * 4;
      idle();
      mode = e[10];
      adsp_n = 1'b0; addr = AW'(base + int'(e[9:8]));
      tick();
      chk(e[10] ? "R5 R7 beat0" : "R4 R7 beat0", dq_out, pat(base + int'(e[7:6])));
      idle(); adv_n = 1'b0;
      tick();
      chk(e[10] ? "R5 beat1" : "R4 beat1", dq_out, pat(base + int'(e[5:4])));
      tick();
      chk(e[10] ? "R5 beat2" : "R4 beat2", dq_out, pat(base + int'(e[3:2])));
      tick();
      chk(e[10] ? "R5 beat3" : "R4 beat3", dq_out, pat(base + int'(e[1:0])));
      tick();
      chk(e[10] ? "R5 wrap" : "R4 wrap", dq_out, pat(base + int'(e[7:6])));
      idle();
    end
    mode = 1'b0;

    // R8 global write overrides byte selects
    idle(); adsc_n = 1'b0; addr = 20; gw_n = 1'b0; bwe_n = 1'b0; bw_n = 4'hF;
    dq_in = 32'h1122_3344;
    tick();
    rd_start(20);
    chk("R8 all lanes", dq_out, 32'h1122_3344);

    // R9 byte write of lanes 0 and 2
    idle(); adsc_n = 1'b0; addr = 20; bwe_n = 1'b0; bw_n = 4'b1010;
    dq_in = 32'hAABB_CCDD;
    tick();
    chk("R11 after write", 32'(dq_oe), 32'd0);
    rd_start(20);
    chk("R9 lanes 0,2", dq_out, 32'h11BB_33DD);

    // R10 processor strobe with write enables is a read
    idle(); adsp_n = 1'b0; addr = 20; gw_n = 1'b0; dq_in = 32'hFFFF_FFFF;
    tick();
    chk("R10 driven", 32'(dq_oe), 32'd1);
    chk("R10 data", dq_out, 32'h11BB_33DD);
    idle();
    rd_start(20);
    chk("R10 unchanged", dq_out, 32'h11BB_33DD);

    // R3 both strobes low: processor strobe rules, no write
    idle(); adsp_n = 1'b0; adsc_n = 1'b0; addr = 5; gw_n = 1'b0; dq_in = 32'h0;
    tick();
    chk("R3 both strobes", dq_out, pat(5));
    // R3 controller strobe without write enables reads
    idle(); adsc_n = 1'b0; addr = 6;
    tick();
    chk("R3 controller read", dq_out, pat(6));

    // R11 asynchronous output enable
    idle(); oe_n = 1'b1;
    tick();
    chk("R11 oe high", 32'(dq_oe), 32'd0);
    chk("R11 data zero", dq_out, 32'd0);
    #2 oe_n = 1'b0;
    #1;
    chk("R11 oe low no edge", dq_out, pat(6));

    // R2 deselected strobe ends burst and blocks write
    idle(); ce2 = 1'b0; adsc_n = 1'b0; addr = 5; gw_n = 1'b0; dq_in = 32'h0;
    tick();
    chk("R2 deselected", 32'(dq_oe), 32'd0);
    idle();
    tick();
    chk("R2 burst ended", 32'(dq_oe), 32'd0);
    idle(); ce1_n = 1'b1; adsp_n = 1'b0; addr = 6;
    tick();
    chk("R2 ce1 high", 32'(dq_oe), 32'd0);
    rd_start(5);
    chk("R2 no write", dq_out, pat(5));

    // R6 hold without advance
    rd_start(4);
    chk("R6 start", dq_out, pat(4));
    tick(); tick();
    chk("R6 held", dq_out, pat(4));

    // R12 sleep blocks advance, write and strobes
    idle(); zz = 1'b1; adv_n = 1'b0; gw_n = 1'b0; dq_in = 32'h0;
    tick();
    chk("R12 undriven", 32'(dq_oe), 32'd0);
    idle();
    tick();
    chk("R12 no advance no write", dq_out, pat(4));
    idle(); adv_n = 1'b0;
    tick();
    chk("R4 advance after sleep", dq_out, pat(5));
    idle(); zz = 1'b1; adsp_n = 1'b0; addr = 8;
    tick();
    idle();
    tick();
    chk("R12 strobe ignored", dq_out, pat(5));

    // R13 absent words
    idle(); adsc_n = 1'b0; gw_n = 1'b0; addr = AW'(1 << MEM_AW) | AW'(7);
    dq_in = 32'h0;
    tick();
    rd_start((1 << MEM_AW) | 7);
    chk("R13 read absent", dq_out, 32'd0);
    rd_start(7);
    chk("R13 alias untouched", dq_out, pat(7));

    summary();
  end
endmodule